// File: doc/BRIEF.md
# Memory Operand Offset Former with Segment Limit Check

This block computes the offset of a memory operand from register, index and displacement inputs, then tests that offset against the limit of the segment it selects. The code segment's default-size flag XORed with an address-size override picks one of two modes. In narrow (16-bit) mode the offset comes from one of eight fixed register pairings. In wide (32-bit) mode the offset is an optional base plus an optional index scaled by 1, 2, 4 or 8.

In narrow mode the sum wraps within 16 bits. The limit test runs on that wrapped value, and the final byte of the access is taken into account. In wide mode offsets can pass 64K. These offsets fault against a 64K limit but pass against a 4 GB limit. The end-of-access sum has one extra bit, so an access that runs past the top of the 32-bit space faults and does not wrap to a low address. An operand that uses a frame-pointer base takes the stack segment's limit. Every other operand takes the data segment's limit.

A request is accepted on any clock edge where `req_valid` is high. The result appears on the registered outputs one cycle later.

Top module: `ea_limit_check`

## Requirements
- R1: The offset is wide (32-bit) when `cs_d` XOR `asz_pfx` is 1 and narrow (16-bit) when it is 0. `out_wide` reports the chosen mode.
- R2: In narrow mode, `form` selects the operand pairing: 0 BX+SI, 1 BX+DI, 2 BP+SI, 3 BP+DI, 4 SI, 5 DI, 6 BP, 7 BX. Only the low 16 bits of each register are used. Any carry out of bit 15 is dropped, so BX=9000h plus SI=7000h gives 0000h. Bits 31:16 of `out_offset` are zero.
- R3: `disp_kind` selects the displacement: 0 or 3 means none, 1 means `disp[7:0]` sign-extended, and 2 means the full displacement (`disp[15:0]` in narrow mode, `disp[31:0]` in wide mode).
- R4: The limit check compares the wrapped narrow offset, not the unwrapped sum.
- R5: A wide offset above FFFFh checked against a limit of FFFFh sets `out_gp`.
- R6: With a limit of FFFFFFFFh, any wide offset whose whole access fits below 2^32 passes.
- R7: `acc_len` gives the access size minus one (0 to 3 means 1 to 4 bytes). `out_gp` is set exactly when offset + `acc_len` is greater than the selected limit.
- R8: The end-of-access sum is formed with one extra bit, so offset FFFFFFFEh with a 4-byte access faults even against a limit of FFFFFFFFh.
- R9: Narrow forms 2, 3 and 6, and wide forms with `use_base` and `base_is_bp` both set, select the stack segment: `out_stack`=1 and the limit is `lim_ss`. All other forms select the data segment: `out_stack`=0 and the limit is `lim_ds`.
- R10: In wide mode the offset is `base_val` (if `use_base`) + (`index_val` << `scale`) (if `use_index`) + displacement, modulo 2^32.
- R11: After reset all outputs are zero. Each accepted request gives `out_valid`=1 with its results exactly one cycle later. With no request, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| cs_d | input | 1 | Code segment default-size flag |
| asz_pfx | input | 1 | Address-size override present |
| form | input | 3 | Narrow-mode register pairing |
| disp_kind | input | 2 | Displacement selector |
| disp | input | 32 | Displacement value |
| reg_bx | input | 32 | BX/EBX value |
| reg_bp | input | 32 | BP/EBP value |
| reg_si | input | 32 | SI/ESI value |
| reg_di | input | 32 | DI/EDI value |
| use_base | input | 1 | Wide mode: base present |
| base_is_bp | input | 1 | Wide mode: base is frame pointer |
| base_val | input | 32 | Wide mode base value |
| use_index | input | 1 | Wide mode: index present |
| index_val | input | 32 | Wide mode index value |
| scale | input | 2 | Index shift (x1, x2, x4, x8) |
| acc_len | input | 2 | Access bytes minus one |
| lim_ds | input | 32 | Data segment limit |
| lim_ss | input | 32 | Stack segment limit |
| out_valid | output | 1 | Result valid |
| out_offset | output | 32 | Computed offset |
| out_wide | output | 1 | Wide mode used |
| out_stack | output | 1 | Stack segment selected |
| out_gp | output | 1 | General-protection fault |

## Verification
The bench builds the block with its default widths: a 32-bit offset and a 16-bit narrow mode. With these widths the 64K wrap, the 64K limit and the 4 GB limit can all be reached with literal values. Register inputs carry nonzero upper halves, so any use of those bits in narrow mode shows up in the offset. Accesses are placed at the last byte below each limit and one byte past it, at both 16-bit and 32-bit boundaries, for each access size that matters.

// File: rtl/ea_limit_check.sv
module ea_limit_check #(
  parameter int OFS_W    = 32,
  parameter int NARROW_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             cs_d,
  input  logic             asz_pfx,
  input  logic [2:0]       form,
  input  logic [1:0]       disp_kind,
  input  logic [OFS_W-1:0] disp,
  input  logic [OFS_W-1:0] reg_bx,
  input  logic [OFS_W-1:0] reg_bp,
  input  logic [OFS_W-1:0] reg_si,
  input  logic [OFS_W-1:0] reg_di,
  input  logic             use_base,
  input  logic             base_is_bp,
  input  logic [OFS_W-1:0] base_val,
  input  logic             use_index,
  input  logic [OFS_W-1:0] index_val,
  input  logic [1:0]       scale,
  input  logic [1:0]       acc_len,
  input  logic [OFS_W-1:0] lim_ds,
  input  logic [OFS_W-1:0] lim_ss,
  output logic             out_valid,
  output logic [OFS_W-1:0] out_offset,
  output logic             out_wide,
  output logic             out_stack,
  output logic             out_gp
);
  localparam int END_W = OFS_W + 1;
  localparam int PAD_W = OFS_W - NARROW_W;

  logic                wide;
  logic [NARROW_W-1:0] n_base, n_index, n_disp, n_sum;
  logic                n_stack;
  logic [OFS_W-1:0]    w_disp, w_base, w_index, w_sum;
  logic [OFS_W-1:0]    ofs, lim;
  logic                stk;
  logic [END_W-1:0]    last_byte;
  logic                fault;

  assign wide = cs_d ^ asz_pfx;

  always_comb begin
    n_base  = '0;
    n_index = '0;
    n_stack = 1'b0;
    case (form)
      3'd0: begin n_base = reg_bx[NARROW_W-1:0]; n_index = reg_si[NARROW_W-1:0]; end
      3'd1: begin n_base = reg_bx[NARROW_W-1:0]; n_index = reg_di[NARROW_W-1:0]; end
      3'd2: begin n_base = reg_bp[NARROW_W-1:0]; n_index = reg_si[NARROW_W-1:0]; n_stack = 1'b1; end
      3'd3: begin n_base = reg_bp[NARROW_W-1:0]; n_index = reg_di[NARROW_W-1:0]; n_stack = 1'b1; end
      3'd4: n_index = reg_si[NARROW_W-1:0];
      3'd5: n_index = reg_di[NARROW_W-1:0];
      3'd6: begin n_base = reg_bp[NARROW_W-1:0]; n_stack = 1'b1; end
      default: n_base = reg_bx[NARROW_W-1:0];
    endcase
  end

  always_comb begin
    case (disp_kind)
      2'd1:    begin n_disp = {{(NARROW_W-8){disp[7]}}, disp[7:0]};
                     w_disp = {{(OFS_W-8){disp[7]}}, disp[7:0]}; end
      2'd2:    begin n_disp = disp[NARROW_W-1:0]; w_disp = disp; end
      default: begin n_disp = '0; w_disp = '0; end
    endcase
  end

  assign n_sum   = n_base + n_index + n_disp;
  assign w_base  = use_base  ? base_val : '0;
  assign w_index = use_index ? (index_val << scale) : '0;
  assign w_sum   = w_base + w_index + w_disp;

  assign ofs       = wide ? w_sum : {{PAD_W{1'b0}}, n_sum};
  assign stk       = wide ? (use_base & base_is_bp) : n_stack;
  assign lim       = stk ? lim_ss : lim_ds;
  assign last_byte = {1'b0, ofs} + {{(END_W-2){1'b0}}, acc_len};
  assign fault     = last_byte > {1'b0, lim};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_offset <= '0;
      out_wide   <= 1'b0;
      out_stack  <= 1'b0;
      out_gp     <= 1'b0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        out_offset <= ofs;
        out_wide   <= wide;
        out_stack  <= stk;
        out_gp     <= fault;
      end
    end
  end
endmodule

// File: rtl/ea_limit_check_sva.sv
module ea_limit_check_sva #(
  parameter int OFS_W    = 32,
  parameter int NARROW_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             cs_d,
  input logic             asz_pfx,
  input logic [1:0]       acc_len,
  input logic [OFS_W-1:0] lim_ds,
  input logic [OFS_W-1:0] lim_ss,
  input logic             out_valid,
  input logic [OFS_W-1:0] out_offset,
  input logic             out_wide,
  input logic             out_stack,
  input logic             out_gp
);
  logic [1:0]       cap_len;
  logic [OFS_W-1:0] cap_ds, cap_ss;
  logic [OFS_W:0]   end_seen, lim_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_len <= '0;
      cap_ds  <= '0;
      cap_ss  <= '0;
    end else if (req_valid) begin
      cap_len <= acc_len;
      cap_ds  <= lim_ds;
      cap_ss  <= lim_ss;
    end
  end

  assign end_seen = {1'b0, out_offset} + {{(OFS_W-1){1'b0}}, cap_len};
  assign lim_seen = {1'b0, out_stack ? cap_ss : cap_ds};

  p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);
  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid);
  p_mode_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_wide == ($past(cs_d) ^ $past(asz_pfx)));
  p_narrow_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_wide) |-> out_offset[OFS_W-1:NARROW_W] == '0);
  p_fault_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_gp == (end_seen > lim_seen)));
endmodule

bind ea_limit_check ea_limit_check_sva #(.OFS_W(OFS_W), .NARROW_W(NARROW_W)) u_chk (.*);

// File: tb/tb_ea_limit_check.sv
module tb_ea_limit_check;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        cs_d = 1'b0, asz_pfx = 1'b0;
  logic [2:0]  form = '0;
  logic [1:0]  disp_kind = '0;
  logic [31:0] disp = '0;
  logic [31:0] reg_bx = '0, reg_bp = '0, reg_si = '0, reg_di = '0;
  logic        use_base = 1'b0, base_is_bp = 1'b0, use_index = 1'b0;
  logic [31:0] base_val = '0, index_val = '0;
  logic [1:0]  scale = '0, acc_len = '0;
  logic [31:0] lim_ds = 32'hFFFF, lim_ss = 32'hFFFF;
  logic        out_valid, out_wide, out_stack, out_gp;
  logic [31:0] out_offset;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  ea_limit_check dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic fire;
    @(negedge clk) req_valid = 1'b1;
    @(negedge clk) req_valid = 1'b0;
  endtask

  task automatic narrow(input logic d, input logic p, input logic [2:0] f,
                        input logic [1:0] dk, input logic [31:0] dv, input logic [1:0] len);
    cs_d = d; asz_pfx = p; form = f; disp_kind = dk; disp = dv; acc_len = len;
    fire();
  endtask

  task automatic wide(input logic ub, input logic bp, input logic [31:0] b,
                      input logic ui, input logic [31:0] ix, input logic [1:0] sc,
                      input logic [1:0] dk, input logic [31:0] dv, input logic [1:0] len);
    cs_d = 1'b0; asz_pfx = 1'b1; use_base = ub; base_is_bp = bp; base_val = b;
    use_index = ui; index_val = ix; scale = sc; disp_kind = dk; disp = dv; acc_len = len;
    fire();
  endtask

  task automatic t_reset;
    check("R11 valid", {31'b0, out_valid}, 0);
    check("R11 offset", out_offset, 0);
    check("R11 gp", {31'b0, out_gp}, 0);
  endtask

  task automatic t_wrap16;
    reg_bx = 32'h1234_9000; reg_si = 32'hABCD_7000; lim_ds = 32'hFFFF;
    narrow(0, 0, 3'd0, 2'd0, 0, 2'd1);
    check("R2 valid", {31'b0, out_valid}, 1);
    check("R2 wrap", out_offset, 32'h0);
    check("R1 narrow", {31'b0, out_wide}, 0);
    narrow(1, 1, 3'd0, 2'd0, 0, 2'd1);
    check("R1 d+pfx narrow", {31'b0, out_wide}, 0);
    check("R1 d+pfx offset", out_offset, 32'h0);
    @(negedge clk);
    check("R11 idle", {31'b0, out_valid}, 0);
  endtask

  task automatic t_trunc_check;
    reg_bx = 32'h0000_FFFF; reg_si = 32'h0000_0002; lim_ds = 32'h10;
    narrow(0, 0, 3'd0, 2'd0, 0, 2'd0);
    check("R4 offset", out_offset, 32'h1);
    check("R4 gp", {31'b0, out_gp}, 0);
  endtask

  task automatic t_disp;
    reg_si = 32'h5555_0005; lim_ds = 32'hFFFF;
    narrow(0, 0, 3'd4, 2'd1, 32'h0000_00FE, 2'd0);
    check("R3 disp8", out_offset, 32'h3);
    reg_di = 32'h0000_FFF0;
    narrow(0, 0, 3'd5, 2'd2, 32'h7777_0020, 2'd0);
    check("R3 disp16", out_offset, 32'h10);
    narrow(0, 0, 3'd5, 2'd3, 32'h0000_0020, 2'd0);
    check("R3 none", out_offset, 32'hFFF0);
  endtask

  task automatic t_segment;
    reg_bp = 32'h0000_0100; reg_di = 32'h0000_0020; lim_ss = 32'h11F; lim_ds = 32'hFFFF;
    narrow(0, 0, 3'd3, 2'd0, 0, 2'd0);
    check("R9 bp+di offset", out_offset, 32'h120);
    check("R9 bp+di stack", {31'b0, out_stack}, 1);
    check("R9 ss limit", {31'b0, out_gp}, 1);
    narrow(0, 0, 3'd6, 2'd1, 32'hFF, 2'd0);
    check("R9 bp offset", out_offset, 32'hFF);
    check("R9 bp gp", {31'b0, out_gp}, 0);
    reg_bx = 32'h120;
    narrow(0, 0, 3'd7, 2'd0, 0, 2'd0);
    check("R9 bx stack", {31'b0, out_stack}, 0);
    check("R9 ds limit", {31'b0, out_gp}, 0);
    wide(1, 1, 32'h200, 0, 0, 2'd0, 2'd0, 0, 2'd0);
    check("R9 wide bp stack", {31'b0, out_stack}, 1);
    check("R9 wide ss limit", {31'b0, out_gp}, 1);
  endtask

  task automatic t_len16;
    reg_bx = 32'h0000_FFFE; lim_ds = 32'hFFFF;
    narrow(0, 0, 3'd7, 2'd0, 0, 2'd3);
    check("R7 4B past", {31'b0, out_gp}, 1);
    narrow(0, 0, 3'd7, 2'd0, 0, 2'd1);
    check("R7 2B fits", {31'b0, out_gp}, 0);
  endtask

  task automatic t_wide_limits;
    lim_ds = 32'hFFFF;
    wide(1, 0, 32'h0001_0000, 0, 0, 2'd0, 2'd0, 0, 2'd0);
    check("R1 wide", {31'b0, out_wide}, 1);
    check("R5 offset", out_offset, 32'h1_0000);
    check("R5 gp", {31'b0, out_gp}, 1);
    lim_ds = 32'hFFFF_FFFF;
    wide(1, 0, 32'h0001_0000, 0, 0, 2'd0, 2'd0, 0, 2'd0);
    check("R6 gp", {31'b0, out_gp}, 0);
    wide(1, 0, 32'hFFFF_FFFC, 0, 0, 2'd0, 2'd0, 0, 2'd3);
    check("R6 top fits", {31'b0, out_gp}, 0);
    wide(1, 0, 32'hFFFF_FFFE, 0, 0, 2'd0, 2'd0, 0, 2'd3);
    check("R8 top wrap", {31'b0, out_gp}, 1);
  endtask

  task automatic t_scaled;
    lim_ds = 32'hFFFF_FFFF;
    wide(1, 0, 32'h1000, 1, 32'h10, 2'd3, 2'd2, 32'hFFFF_FFFF, 2'd0);
    check("R10 scaled", out_offset, 32'h107F);
    check("R10 stack", {31'b0, out_stack}, 0);
    wide(0, 0, 0, 1, 32'h100, 2'd1, 2'd1, 32'h80, 2'd0);
    check("R10 idx disp8", out_offset, 32'h180);
    wide(1, 0, 32'hFFFF_FFF0, 0, 0, 2'd0, 2'd2, 32'h20, 2'd0);
    check("R10 mod 2^32", out_offset, 32'h10);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_wrap16();
        t_trunc_check();
        t_disp();
        t_segment();
        t_len16();
        t_wide_limits();
        t_scaled();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule